// File: doc/BRIEF.md
# Bit-Manipulation Execute Stage

This block is the execute step for a handful of single-source bit-manipulation instructions in a 32-bit RISC pipeline. Each cycle it may accept one instruction word together with the value of its source register, qualified by a valid strobe. From the opcode and the 16-bit function field it picks one of five operations: sign extension from a byte, sign extension from a halfword, leading-zero count, full byte reversal, or exchange of the two halfwords. It then hands back the result and the destination register index one clock later.

The instruction uses MSB-first bit numbering. Bit 0 is the most significant bit of the word, which is `in_insn[31]` on the port. The source operand reaches the block already read from the register file, so the source-register field is not decoded here. An instruction whose opcode is wrong, or whose function code is not one of the five known values, is returned as valid with an illegal flag and a zero result. The leading-zero counter has two selectable structures, and all data widths are parameters checked at elaboration.

Top module: `bmx_unit`

## Requirements
- R1: Decoding takes the primary opcode from `in_insn[31:26]`, which must equal 6'b100100, and the destination index from `in_insn[25:21]`. `out_rd` equals that destination field one cycle after acceptance.
- R2: Function code 0x0060 in `in_insn[15:0]` returns the low byte of `in_opa` with bit 7 copied into every higher bit.
- R3: Function code 0x0061 returns the low halfword of `in_opa` with bit 15 copied into every higher bit.
- R4: Function code 0x00E0 returns the number of zero bits above the highest set bit of `in_opa`. An all-zero operand returns 32.
- R5: Function code 0x01E0 returns `in_opa` with its byte order fully reversed, so byte 0 moves to byte 3 and byte 3 moves to byte 0.
- R6: Function code 0x01E2 returns `in_opa` with its upper and lower 16-bit halves exchanged.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R8: A wrong opcode or an unlisted function code gives `out_illegal`=1 together with `out_valid`=1 and `out_result`=0. `out_illegal` is never high without `out_valid`.
- R9: While synchronous reset `rst` is high, every output is cleared to zero on the clock edge.
- R10: In a cycle with `in_valid` low, `out_result` and `out_rd` keep their previous values.
- R11: The source-register field `in_insn[20:16]` has no effect on `out_result` or `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and operand are present this cycle |
| in_insn | input | 32 | Instruction word, MSB-first fields |
| in_opa | input | DATA_W (32) | Source operand value |
| out_valid | output | 1 | Result registers hold a new instruction |
| out_result | output | DATA_W (32) | Operation result, zero when illegal |
| out_rd | output | 5 | Destination register index |
| out_illegal | output | 1 | Instruction not recognised |

## Verification
The checks assume that `in_insn` and `in_opa` are known, not X, whenever `in_valid` is high. The combinational leading-zero checks skip any operand with unknown bits. The bench drives every input on the falling clock edge and releases `in_valid` to a defined low between scenarios, so each sampled edge sees stable, fully known values. Operands are chosen to reach the boundaries: the sign bit set and clear, the highest bit alone, the lowest bit alone and all zeros. Instruction words are built field by field, so that the opcode, the function code and the source-register field can each be varied on their own.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

   localparam int INSN_W  = 32;
   localparam int REG_W   = 5;
   localparam int MAJOR_W = 6;
   localparam int FUNC_W  = 16;

   localparam logic [MAJOR_W-1:0] MAJOR_BITOPS = 6'b100100;

   localparam logic [FUNC_W-1:0] FN_EXT_BYTE = 16'h0060;
   localparam logic [FUNC_W-1:0] FN_EXT_HALF = 16'h0061;
   localparam logic [FUNC_W-1:0] FN_LZCOUNT  = 16'h00E0;
   localparam logic [FUNC_W-1:0] FN_REV_BYTE = 16'h01E0;
   localparam logic [FUNC_W-1:0] FN_ROT_HALF = 16'h01E2;

   typedef enum logic [2:0] {
      OPK_NONE     = 3'd0,
      OPK_EXT_BYTE = 3'd1,
      OPK_EXT_HALF = 3'd2,
      OPK_LZCOUNT  = 3'd3,
      OPK_REV_BYTE = 3'd4,
      OPK_ROT_HALF = 3'd5
   } opkind_t;

   typedef struct packed {
      opkind_t            kind;
      logic               bad;
      logic [REG_W-1:0]   dst;
   } decoded_t;

endpackage

// File: rtl/bmx_decode.sv
module bmx_decode
   import bmx_pkg::*;
(
   input  logic [INSN_W-1:0] insn,
   output decoded_t          dec
);

   // MSB-first field layout: bits 0-5 major, 6-10 destination, 11-15 source, 16-31 function
   localparam int MAJOR_LO = INSN_W - MAJOR_W;
   localparam int DST_LO   = MAJOR_LO - REG_W;

   logic [MAJOR_W-1:0] major;
   logic [FUNC_W-1:0]  func;
   opkind_t            kind_raw;

   assign major = insn[INSN_W-1 -: MAJOR_W];
   assign func  = insn[FUNC_W-1:0];

   always_comb begin
      unique case (func)
         FN_EXT_BYTE: kind_raw = OPK_EXT_BYTE;
         FN_EXT_HALF: kind_raw = OPK_EXT_HALF;
         FN_LZCOUNT:  kind_raw = OPK_LZCOUNT;
         FN_REV_BYTE: kind_raw = OPK_REV_BYTE;
         FN_ROT_HALF: kind_raw = OPK_ROT_HALF;
         default:     kind_raw = OPK_NONE;
      endcase
   end

   always_comb begin
      dec.dst  = insn[DST_LO +: REG_W];
      dec.kind = (major == MAJOR_BITOPS) ? kind_raw : OPK_NONE;
      dec.bad  = (dec.kind == OPK_NONE);
   end

endmodule

// File: rtl/bmx_lzc.sv
module bmx_lzc #(
   parameter int DATA_W    = 32,
   parameter int LZC_STYLE = 1,
   localparam int CNT_W    = $clog2(DATA_W + 1)
) (
   input  logic [DATA_W-1:0] val,
   output logic [CNT_W-1:0]  cnt
);

   localparam int CHUNK_W = 8;
   localparam int N_CHUNK = DATA_W / CHUNK_W;

   if (LZC_STYLE != 0 && LZC_STYLE != 1) begin : g_bad_style
      $error("bmx_lzc: LZC_STYLE must be 0 (bit scan) or 1 (byte chunks)");
   end
   if (DATA_W % CHUNK_W != 0) begin : g_bad_width
      $error("bmx_lzc: DATA_W must be a whole number of bytes");
   end

   if (LZC_STYLE == 0) begin : g_scan
      always_comb begin
         logic hit;
         hit = 1'b0;
         cnt = '0;
         for (int i = DATA_W - 1; i >= 0; i--) begin
            if (!hit) begin
               if (val[i]) hit = 1'b1;
               else        cnt = cnt + CNT_W'(1);
            end
         end
      end
   end else begin : g_chunk
      logic [N_CHUNK-1:0] nz;
      logic [3:0]         part [N_CHUNK];

      for (genvar c = 0; c < N_CHUNK; c++) begin : g_part
         logic [CHUNK_W-1:0] seg;
         assign seg   = val[c*CHUNK_W +: CHUNK_W];
         assign nz[c] = |seg;
         always_comb begin
            logic hit;
            hit = 1'b0;
            part[c] = '0;
            for (int b = CHUNK_W - 1; b >= 0; b--) begin
               if (!hit) begin
                  if (seg[b]) hit = 1'b1;
                  else        part[c] = part[c] + 4'd1;
               end
            end
         end
      end

      always_comb begin
         logic hit;
         hit = 1'b0;
         cnt = '0;
         for (int c = N_CHUNK - 1; c >= 0; c--) begin
            if (!hit) begin
               if (nz[c]) begin
                  hit = 1'b1;
                  cnt = cnt + CNT_W'(part[c]);
               end else begin
                  cnt = cnt + CNT_W'(CHUNK_W);
               end
            end
         end
      end
   end

endmodule

// File: rtl/bmx_ops.sv
module bmx_ops
   import bmx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int LZC_STYLE = 1
) (
   input  opkind_t           kind,
   input  logic [DATA_W-1:0] opa,
   output logic [DATA_W-1:0] res
);

   localparam int HALF_W  = DATA_W / 2;
   localparam int N_BYTES = DATA_W / 8;
   localparam int CNT_W   = $clog2(DATA_W + 1);

   if (DATA_W % 16 != 0 || DATA_W < 16) begin : g_bad_width
      $error("bmx_ops: DATA_W must be a positive multiple of 16");
   end

   logic [DATA_W-1:0] ext_b, ext_h, rev_b, rot_h, lz_ext;
   logic [CNT_W-1:0]  lz_cnt;

   assign ext_b = {{(DATA_W-8){opa[7]}}, opa[7:0]};
   assign ext_h = {{(DATA_W-16){opa[15]}}, opa[15:0]};
   assign rot_h = {opa[HALF_W-1:0], opa[DATA_W-1:HALF_W]};

   for (genvar b = 0; b < N_BYTES; b++) begin : g_rev
      assign rev_b[b*8 +: 8] = opa[(N_BYTES-1-b)*8 +: 8];
   end

   bmx_lzc #(
      .DATA_W    (DATA_W),
      .LZC_STYLE (LZC_STYLE)
   ) u_lzc (
      .val (opa),
      .cnt (lz_cnt)
   );

   assign lz_ext = DATA_W'(lz_cnt);

   always_comb begin
      unique case (kind)
         OPK_EXT_BYTE: res = ext_b;
         OPK_EXT_HALF: res = ext_h;
         OPK_LZCOUNT:  res = lz_ext;
         OPK_REV_BYTE: res = rev_b;
         OPK_ROT_HALF: res = rot_h;
         default:      res = '0;
      endcase
   end

   always_comb begin
      if (!$isunknown(opa)) begin
         AST_LZC_IN_RANGE: assert (int'(lz_cnt) <= DATA_W); // R4
         if (int'(lz_cnt) < DATA_W) begin
            AST_LZC_FIRST_ONE: assert (opa[DATA_W-1-int'(lz_cnt)]); // R4
         end
      end
   end

endmodule

// File: rtl/bmx_unit.sv
module bmx_unit
   import bmx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int LZC_STYLE = 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [INSN_W-1:0]    in_insn,
   input  logic [DATA_W-1:0]    in_opa,
   output logic                 out_valid,
   output logic [DATA_W-1:0]    out_result,
   output logic [REG_W-1:0]     out_rd,
   output logic                 out_illegal
);

   decoded_t          dec;
   logic [DATA_W-1:0] op_res;

   bmx_decode u_dec (
      .insn (in_insn),
      .dec  (dec)
   );

   bmx_ops #(
      .DATA_W    (DATA_W),
      .LZC_STYLE (LZC_STYLE)
   ) u_ops (
      .kind (dec.kind),
      .opa  (in_opa),
      .res  (op_res)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_illegal <= 1'b0;
         out_result  <= '0;
         out_rd      <= '0;
      end else begin
         out_valid   <= in_valid;
         out_illegal <= in_valid & dec.bad;
         if (in_valid) begin
            out_result <= dec.bad ? '0 : op_res;
            out_rd     <= dec.dst;
         end
      end
   end

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R7
   AST_ILLEGAL_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> out_valid); // R8
   AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> out_result == '0); // R8
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_result) && $stable(out_rd))); // R10
   AST_DEST_FIELD: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_rd == $past(in_insn[25:21])); // R1

endmodule

// File: tb/bmx_unit_test.sv
`timescale 1ns/100ps
module bmx_unit_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_insn = '0;
   logic [31:0] in_opa = '0;
   logic        out_valid;
   logic [31:0] out_result;
   logic [4:0]  out_rd;
   logic        out_illegal;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   bmx_unit uut (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (in_valid),
      .in_insn     (in_insn),
      .in_opa      (in_opa),
      .out_valid   (out_valid),
      .out_result  (out_result),
      .out_rd      (out_rd),
      .out_illegal (out_illegal)
   );

   function automatic logic [31:0] mk(logic [5:0] major, logic [4:0] rd,
                                      logic [4:0] ra, logic [15:0] fn);
      return {major, rd, ra, fn};
   endfunction

   function automatic logic [31:0] ref_lz(logic [31:0] v);
      int n = 0;
      for (int i = 31; i >= 0; i--) begin
         if (v[i]) return 32'(n);
         n++;
      end
      return 32'd32;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // drive one instruction, check outputs one cycle later
   task automatic run_one(string req, logic [31:0] insn, logic [31:0] opa,
                          logic [31:0] exp_res, logic exp_ill);
      @(negedge clk);
      in_valid = 1'b1; in_insn = insn; in_opa = opa;
      @(negedge clk);
      in_valid = 1'b0;
      chk({req, " valid"}, 32'(out_valid), 32'd1);
      chk({req, " result"}, out_result, exp_res);
      chk({req, " rd R1"}, 32'(out_rd), 32'(insn[25:21]));
      chk({req, " illegal"}, 32'(out_illegal), 32'(exp_ill));
   endtask

   task automatic t_reset;
      rst = 1'b1;
      in_valid = 1'b1; in_insn = mk(6'b100100, 5'd7, 5'd0, 16'h01E0); in_opa = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      chk("R9 valid", 32'(out_valid), 32'd0);
      chk("R9 result", out_result, 32'd0);
      chk("R9 rd", 32'(out_rd), 32'd0);
      chk("R9 illegal", 32'(out_illegal), 32'd0);
      in_valid = 1'b0;
      rst = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_ext;
      run_one("R2 neg", mk(6'b100100, 5'd3, 5'd1, 16'h0060), 32'h1234_5680, 32'hFFFF_FF80, 1'b0);
      run_one("R2 pos", mk(6'b100100, 5'd4, 5'd1, 16'h0060), 32'hABCD_EF7F, 32'h0000_007F, 1'b0);
      run_one("R3 neg", mk(6'b100100, 5'd5, 5'd2, 16'h0061), 32'h0000_8001, 32'hFFFF_8001, 1'b0);
      run_one("R3 pos", mk(6'b100100, 5'd6, 5'd2, 16'h0061), 32'hFFFF_7FFF, 32'h0000_7FFF, 1'b0);
   endtask

   task automatic t_lz;
      logic [31:0] pats [6] = '{32'h0, 32'h1, 32'h8000_0000, 32'h0001_0000,
                                32'h00FF_0000, 32'h0000_0100};
      foreach (pats[k]) begin
         run_one("R4 lz", mk(6'b100100, 5'(k), 5'd9, 16'h00E0), pats[k], ref_lz(pats[k]), 1'b0);
      end
   endtask

   task automatic t_swap;
      run_one("R5 rev", mk(6'b100100, 5'd10, 5'd3, 16'h01E0), 32'h1122_3344, 32'h4433_2211, 1'b0);
      run_one("R5 rev2", mk(6'b100100, 5'd11, 5'd3, 16'h01E0), 32'h8000_00FF, 32'hFF00_0080, 1'b0);
      run_one("R6 rot", mk(6'b100100, 5'd12, 5'd4, 16'h01E2), 32'h1122_3344, 32'h3344_1122, 1'b0);
   endtask

   task automatic t_illegal;
      run_one("R8 major", mk(6'b100101, 5'd13, 5'd0, 16'h0060), 32'hFFFF_FF80, 32'd0, 1'b1);
      run_one("R8 func", mk(6'b100100, 5'd14, 5'd0, 16'h0062), 32'h1234_5678, 32'd0, 1'b1);
      run_one("R8 func2", mk(6'b100100, 5'd15, 5'd0, 16'h01E1), 32'h1234_5678, 32'd0, 1'b1);
   endtask

   task automatic t_src_field;
      run_one("R11 ra0", mk(6'b100100, 5'd16, 5'd0, 16'h01E2), 32'hDEAD_BEEF, 32'hBEEF_DEAD, 1'b0);
      run_one("R11 ra31", mk(6'b100100, 5'd16, 5'd31, 16'h01E2), 32'hDEAD_BEEF, 32'hBEEF_DEAD, 1'b0);
   endtask

   task automatic t_latency_hold;
      @(negedge clk);
      in_valid = 1'b1; in_insn = mk(6'b100100, 5'd20, 5'd0, 16'h0060); in_opa = 32'h0000_00F0;
      @(negedge clk);
      chk("R7 first valid", 32'(out_valid), 32'd1);
      chk("R7 first result", out_result, 32'hFFFF_FFF0);
      in_insn = mk(6'b100100, 5'd21, 5'd0, 16'h01E2); in_opa = 32'hAAAA_5555;
      @(negedge clk);
      in_valid = 1'b0;
      in_insn = mk(6'b100100, 5'd29, 5'd0, 16'h00E0); in_opa = 32'h0;
      chk("R7 second valid", 32'(out_valid), 32'd1);
      chk("R7 second result", out_result, 32'h5555_AAAA);
      chk("R7 second rd", 32'(out_rd), 32'd21);
      @(negedge clk);
      chk("R7 idle valid", 32'(out_valid), 32'd0);
      chk("R10 hold result", out_result, 32'h5555_AAAA);
      chk("R10 hold rd", 32'(out_rd), 32'd21);
      in_insn = mk(6'b100101, 5'd30, 5'd0, 16'h0000);
      @(negedge clk);
      chk("R8 idle illegal", 32'(out_illegal), 32'd0);
      chk("R10 hold result 2", out_result, 32'h5555_AAAA);
   endtask

   initial begin
      t_reset();
      t_ext();
      t_lz();
      t_swap();
      t_illegal();
      t_src_field();
      t_latency_hold();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule